// File: doc/BRIEF.md
# Shadow Commit and Abort Controller

This controller sits between a group of functional units and the register write-back path of an out-of-order core. It tracks which units hold an issued instruction. It also records, for each unit, which other units' instructions could still raise an exception ahead of it. A unit may commit its result only when nothing shadows it. When a unit reports that its instruction completed without an exception, the shadow that unit cast on others is lifted.

Any exception reported by a busy unit raises a single global abort. In the same clock step, the abort cancels the work of every unit and wipes all shadow state. Nothing is saved and nothing is restored.

For interrupt entry, an interrupt request freezes instruction issue. The controller then lets the units still in flight finish and write back. It flags the machine as drained once none of them is busy, and the handler may start from that point.

Top module: `shadow_commit_ctl`

## Requirements
- R1: After reset, no unit is busy, no shadow is recorded, and issue_hold, abort, drained and every go_write bit are 0.
- R2: issue_vld with unit index issue_fu marks that unit busy from the next cycle. The request is ignored when the unit is already busy, when issue_hold is 1, or when abort is 1 in that cycle.
- R3: go_write[i] is 1 exactly when unit i is busy, fu_ready[i] is 1, no unit shadows unit i, and abort is 0. The unit is no longer busy in the cycle after its grant.
- R4: shd_req[i] with shd_src = j records that unit j shadows unit i from the next cycle. This happens only when both units are busy and i differs from j; otherwise the request has no effect.
- R5: fu_ok[j] lifts every shadow cast by unit j from the next cycle on. It takes precedence over a same-cycle request to record a shadow from j.
- R6: abort is the OR of fu_exc over the busy units. In the cycle after abort, every unit is idle and all shadows are gone, so a held exception gives an abort of exactly one cycle.
- R7: No go_write bit is 1 in a cycle where abort is 1, and a cancelled unit is never granted afterwards.
- R8: irq_req sets issue_hold from the next cycle. issue_hold stays set until a cycle in which irq_done is 1 and irq_req is 0, and clears after that cycle.
- R9: drained is 1 exactly when issue_hold is 1 and no unit is busy.
- R10: fu_exc from a unit that is not busy raises no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | Issue of an instruction to a unit |
| issue_fu | input | IW | Index of the unit being issued |
| shd_req | input | N | Per-unit request to be shadowed |
| shd_src | input | IW | Index of the unit casting the shadow |
| fu_ready | input | N | Per-unit result ready |
| fu_ok | input | N | Per-unit completion without exception |
| fu_exc | input | N | Per-unit exception trigger |
| irq_req | input | 1 | Interrupt entry request |
| irq_done | input | 1 | Handler has begun; release the issue hold |
| go_write | output | N | Per-unit write-back grant |
| abort | output | 1 | Global cancel of all units |
| issue_hold | output | 1 | Issue is frozen |
| drained | output | 1 | Issue frozen and no unit busy |
| fu_busy | output | N | Per-unit busy state |

## Verification
The bench sets up a unit that is ready while still shadowed, and also lifts the shadow in the very cycle the unit is ready. A design that lifted the shadow combinationally would grant one cycle early. It fires an exception together with a ready result and with a new issue in the same cycle. A leaky design would then commit or start cancelled work, or hold abort for two cycles when the exception is held.

It also tries self-shadowing, shadowing from an idle unit, a shadow request that coincides with its own release, and an exception from an idle unit. Each of these would leave a unit blocked forever or abort for no reason. The interrupt sequence checks that issue is refused while the hold is on and that drained appears only once the last unit has written back.

// File: rtl/shadow_commit_ctl.sv
module shadow_commit_ctl #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_vld,
  input  logic [IW-1:0] issue_fu,
  input  logic [N-1:0]  shd_req,
  input  logic [IW-1:0] shd_src,
  input  logic [N-1:0]  fu_ready,
  input  logic [N-1:0]  fu_ok,
  input  logic [N-1:0]  fu_exc,
  input  logic          irq_req,
  input  logic          irq_done,
  output logic [N-1:0]  go_write,
  output logic          abort,
  output logic          issue_hold,
  output logic          drained,
  output logic [N-1:0]  fu_busy
);

  logic [N-1:0]   busy_q;
  logic [N*N-1:0] shd_q;
  logic [N-1:0]   row_clear;
  logic [N-1:0]   issue_hit;
  logic           hold_q;

  assign abort      = |(fu_exc & busy_q);
  assign go_write   = busy_q & fu_ready & row_clear & {N{~abort}};
  assign issue_hold = hold_q;
  assign drained    = hold_q & ~|busy_q;
  assign fu_busy    = busy_q;

  for (genvar i = 0; i < N; i++) begin : g_unit
    assign row_clear[i] = ~|shd_q[i*N +: N];
    assign issue_hit[i] = issue_vld & ~hold_q & ~abort & ~busy_q[i] & (issue_fu == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n || abort)  busy_q[i] <= 1'b0;
      else if (issue_hit[i]) busy_q[i] <= 1'b1;
      else if (go_write[i])  busy_q[i] <= 1'b0;
    end

    for (genvar j = 0; j < N; j++) begin : g_src
      logic set_c;
      if (i == j) begin : g_self
        assign set_c = 1'b0;
      end else begin : g_other
        assign set_c = shd_req[i] & (shd_src == IW'(j)) & busy_q[i] & busy_q[j];
      end

      always_ff @(posedge clk) begin
        if (!rst_n || abort)   shd_q[i*N+j] <= 1'b0;
        else if (fu_ok[j])     shd_q[i*N+j] <= 1'b0;
        else if (issue_hit[i]) shd_q[i*N+j] <= 1'b0;
        else if (set_c)        shd_q[i*N+j] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       hold_q <= 1'b0;
    else if (irq_req) hold_q <= 1'b1;
    else if (irq_done) hold_q <= 1'b0;
  end

endmodule

// File: rtl/shadow_commit_ctl_chk.sv
module shadow_commit_ctl_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           abort,
  input logic           issue_hold,
  input logic           irq_req,
  input logic [N-1:0]   go_write,
  input logic [N-1:0]   fu_busy,
  input logic [N-1:0]   fu_ok,
  input logic [N*N-1:0] shd
);

  assert_abort_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);

  assert_abort_idles_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (fu_busy == '0 && shd == '0));

  assert_no_grant_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> go_write == '0);

  assert_grant_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go_write & ~fu_busy) == '0);

  assert_hold_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_hold |=> (fu_busy & ~$past(fu_busy)) == '0);

  assert_hold_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issue_hold) |-> $past(irq_req));

  for (genvar j = 0; j < N; j++) begin : g_col
    logic [N-1:0] col;
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign col[i] = shd[i*N+j];
    end
    assert_release_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fu_ok[j] |=> col == '0);
  end

endmodule

bind shadow_commit_ctl shadow_commit_ctl_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .abort(abort), .issue_hold(issue_hold),
  .irq_req(irq_req), .go_write(go_write), .fu_busy(fu_busy),
  .fu_ok(fu_ok), .shd(shd_q)
);

// File: tb/shadow_commit_ctl_tb.sv
module shadow_commit_ctl_tb_top;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_vld = 1'b0;
  logic [IW-1:0] issue_fu = '0;
  logic [N-1:0] shd_req = '0;
  logic [IW-1:0] shd_src = '0;
  logic [N-1:0] fu_ready = '0, fu_ok = '0, fu_exc = '0;
  logic irq_req = 1'b0, irq_done = 1'b0;
  logic [N-1:0] go_write, fu_busy;
  logic abort, issue_hold, drained;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  shadow_commit_ctl #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_fu(issue_fu),
    .shd_req(shd_req), .shd_src(shd_src), .fu_ready(fu_ready), .fu_ok(fu_ok),
    .fu_exc(fu_exc), .irq_req(irq_req), .irq_done(irq_done),
    .go_write(go_write), .abort(abort), .issue_hold(issue_hold),
    .drained(drained), .fu_busy(fu_busy)
  );

  typedef struct packed {
    logic iv; logic [1:0] ifu; logic [3:0] sreq; logic [1:0] ssrc;
    logic [3:0] rdy; logic [3:0] ok; logic [3:0] exc; logic irq; logic done;
    logic [3:0] eg; logic ea; logic eh; logic ed; logic [3:0] eb;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{1'b1,2'd0,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h0},
    '{1'b1,2'd1,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h1},
    '{1'b0,2'd0,4'h2,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h3},
    '{1'b0,2'd0,4'h0,2'd0,4'h2,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h3},
    '{1'b0,2'd0,4'h0,2'd0,4'h2,4'h1,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h3},
    '{1'b0,2'd0,4'h0,2'd0,4'h2,4'h0,4'h0,1'b0,1'b0, 4'h2,1'b0,1'b0,1'b0,4'h3},
    '{1'b0,2'd0,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h1},
    '{1'b0,2'd0,4'h0,2'd0,4'h1,4'h0,4'h0,1'b0,1'b0, 4'h1,1'b0,1'b0,1'b0,4'h1},
    '{1'b0,2'd0,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h0},
    '{1'b1,2'd2,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h0},
    '{1'b1,2'd3,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h4},
    '{1'b0,2'd0,4'h8,2'd2,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'hC},
    '{1'b1,2'd0,4'h0,2'd0,4'h8,4'h0,4'h4,1'b0,1'b0, 4'h0,1'b1,1'b0,1'b0,4'hC},
    '{1'b0,2'd0,4'h0,2'd0,4'h8,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h0},
    '{1'b0,2'd0,4'h0,2'd0,4'h0,4'h0,4'h2,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h0},
    '{1'b1,2'd1,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h0},
    '{1'b0,2'd0,4'h0,2'd0,4'h0,4'h0,4'h0,1'b1,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h2},
    '{1'b1,2'd0,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b1,1'b0,4'h2},
    '{1'b0,2'd0,4'h0,2'd0,4'h2,4'h0,4'h0,1'b0,1'b0, 4'h2,1'b0,1'b1,1'b0,4'h2},
    '{1'b0,2'd0,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b1,1'b1,4'h0},
    '{1'b0,2'd0,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b1, 4'h0,1'b0,1'b1,1'b1,4'h0},
    '{1'b1,2'd0,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h0},
    '{1'b0,2'd0,4'h1,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h1},
    '{1'b0,2'd0,4'h0,2'd0,4'h1,4'h0,4'h0,1'b0,1'b0, 4'h1,1'b0,1'b0,1'b0,4'h1},
    '{1'b1,2'd1,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h0},
    '{1'b0,2'd0,4'h2,2'd3,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h2},
    '{1'b0,2'd0,4'h0,2'd0,4'h2,4'h0,4'h0,1'b0,1'b0, 4'h2,1'b0,1'b0,1'b0,4'h2},
    '{1'b1,2'd2,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h0},
    '{1'b1,2'd3,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h4},
    '{1'b0,2'd0,4'h8,2'd2,4'h0,4'h4,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'hC},
    '{1'b0,2'd0,4'h0,2'd0,4'h8,4'h0,4'h0,1'b0,1'b0, 4'h8,1'b0,1'b0,1'b0,4'hC},
    '{1'b0,2'd0,4'h0,2'd0,4'h4,4'h0,4'h0,1'b0,1'b0, 4'h4,1'b0,1'b0,1'b0,4'h4},
    '{1'b0,2'd0,4'h0,2'd0,4'h0,4'h0,4'h0,1'b0,1'b0, 4'h0,1'b0,1'b0,1'b0,4'h0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic idle_inputs();
    issue_vld = 1'b0; issue_fu = '0; shd_req = '0; shd_src = '0;
    fu_ready = '0; fu_ok = '0; fu_exc = '0; irq_req = 1'b0; irq_done = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) step();
    #1;
    chk("R1 busy", fu_busy, 0);
    chk("R1 go_write", go_write, 0);
    chk("R1 abort", abort, 0);
    chk("R1 issue_hold", issue_hold, 0);
    chk("R1 drained", drained, 0);
    step();
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      step();
      issue_vld = VEC[k].iv; issue_fu = VEC[k].ifu;
      shd_req = VEC[k].sreq; shd_src = VEC[k].ssrc;
      fu_ready = VEC[k].rdy; fu_ok = VEC[k].ok; fu_exc = VEC[k].exc;
      irq_req = VEC[k].irq; irq_done = VEC[k].done;
      #1;
      chk("R3/R4/R5/R7 go_write", go_write, VEC[k].eg);
      chk("R6/R10 abort", abort, VEC[k].ea);
      chk("R8 issue_hold", issue_hold, VEC[k].eh);
      chk("R9 drained", drained, VEC[k].ed);
      chk("R2 busy", fu_busy, VEC[k].eb);
    end

    // R6 R7: held exception, abort for one cycle, ready unit not granted
    step(); idle_inputs(); issue_vld = 1'b1; issue_fu = 2'd0;
    step(); issue_fu = 2'd1;
    step(); idle_inputs(); fu_exc = 4'h1; fu_ready = 4'h2; #1;
    chk("R6 abort rises", abort, 1);
    chk("R7 no grant in abort", go_write, 0);
    step(); #1;
    chk("R6 abort single cycle", abort, 0);
    chk("R6 all idle", fu_busy, 0);
    chk("R7 cancelled not granted", go_write, 0);

    // R1: reset in the middle of work
    step(); idle_inputs(); issue_vld = 1'b1; issue_fu = 2'd3; irq_req = 1'b1;
    step(); idle_inputs(); rst_n = 1'b0;
    step(); #1;
    chk("R1 busy after mid reset", fu_busy, 0);
    chk("R1 hold after mid reset", issue_hold, 0);
    chk("R1 drained after mid reset", drained, 0);
    rst_n = 1'b1;
    step();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #40000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule